// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits between a multi-channel converter core and its output serializer. On every word boundary, marked by a sample strobe, it either forwards the converter samples or replaces them with a known 12-bit test word. A receiver uses these words to check its capture timing, its word framing and its data paths. A 3-bit mode input selects all zeros, all ones, toggle, a programmable custom word, a frame sync word or a deskew word. Every pattern word is driven onto all four channel outputs at once.

Each channel output is a 14-bit frame field. In 12x serialization the word occupies bits 11:0 and bits 13:12 are zero. In 14x serialization the 12-bit word is left-aligned in bits 13:2, with bits 1:0 zero. The sync word and the all-zeros/all-ones words instead fill every active frame bit. In two-wire lane mode the serializer sends the upper half of the active field on one wire and the lower half on the other. The custom word is programmed through two 6-bit halves, each with its own write enable. A new custom word is used only once both halves have been written.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: Mode 1 outputs all active frame bits low. Mode 2 outputs all active frame bits high: 0x0FFF in 12x and 0x3FFF in 14x.
- R2: Mode 3 (toggle) outputs 101010101010 on the first word after any mode change. On each later word while the mode is held, it alternates with 010101010101, counting words rather than clock cycles.
- R3: The custom word takes bits 11..6 from the high half and bits 5..0 from the low half. A new value is used only after both halves have been written since the last update, in either order or in the same cycle. A single-half write alone leaves the custom output unchanged.
- R4: Mode 6 (deskew) outputs the constant word 101010101010 on every word.
- R5: In modes 1 to 6, all four channel outputs carry the same frame.
- R6: In mode 5 (sync), each wire carries a field of 12/wires or 14/wires bits. The field is ceil(half) ones followed by zeros, MSB first, and is repeated on every wire. The expected values are 0xFC0 (1-wire 12x), 0x3F80 (1-wire 14x), 0xE38 (2-wire 12x) and 0x3C78 (2-wire 14x).
- R7: Modes 0 and 7 pass each channel's own 12-bit sample through unchanged.
- R8: In 12x, each 12-bit word sits in frame bits 11:0 with bits 13:12 zero. In 14x, it sits in bits 13:2 with bits 1:0 zero. This applies to the toggle, custom, deskew and passthrough words.
- R9: Mode, lane mode and serialization are sampled only on a strobe cycle. The frames and valid_o update one clock after the strobe. Without a strobe, valid_o is low and the frames hold their value.
- R10: After reset, all frames are zero, valid_o is low and the custom word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Pattern mode select |
| two_wire_i | input | 1 | 1 = two wires per channel, 0 = one wire |
| ser14_i | input | 1 | 1 = 14x serialization, 0 = 12x |
| cust_hi_i | input | 6 | Custom word bits 11..6 |
| cust_hi_we_i | input | 1 | Write enable for the high custom half |
| cust_lo_i | input | 6 | Custom word bits 5..0 |
| cust_lo_we_i | input | 1 | Write enable for the low custom half |
| sample_valid_i | input | 1 | Word-boundary strobe with converter samples |
| sample_i | input | 48 | Four 12-bit samples, channel k at [12k+11:12k] |
| frame_o | output | 56 | Four 14-bit frames, channel k at [14k+13:14k] |
| valid_o | output | 1 | Frame strobe, one clock after sample_valid_i |

## Verification
On every cycle, the assertions check the strobe-to-valid latency and the holding of frames between strobes. They also check that the four channels match in pattern modes, and the exact zero, one, deskew and passthrough values. Inside the custom register they check that a lone half-write never changes the active word. The toggle phase restart after a mode change, the sync layouts for each lane and serialization setting, and the write orderings of the custom halves depend on stimulus history. Only the bench's sequences show these.

// File: rtl/atpg_pkg.sv
package atpg_pkg;
  localparam int WORD_W  = 12;
  localparam int PAD_W   = 2;
  localparam int FRAME_W = WORD_W + PAD_W;
  localparam int HALF_W  = WORD_W / 2;

  typedef enum logic [2:0] {
    MODE_PASS    = 3'd0,
    MODE_ZEROS   = 3'd1,
    MODE_ONES    = 3'd2,
    MODE_TOGGLE  = 3'd3,
    MODE_CUSTOM  = 3'd4,
    MODE_SYNC    = 3'd5,
    MODE_DESKEW  = 3'd6,
    MODE_PASS_HI = 3'd7
  } mode_e;

  // place a 12-bit word in the frame field
  function automatic logic [FRAME_W-1:0] align_word(logic [WORD_W-1:0] w, logic ser14);
    return ser14 ? {w, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, w};
  endfunction

  function automatic logic [FRAME_W-1:0] active_mask(logic ser14);
    return ser14 ? {FRAME_W{1'b1}} : {{PAD_W{1'b0}}, {WORD_W{1'b1}}};
  endfunction

  // alternating word; phase 0 starts with a one in the MSB
  function automatic logic [WORD_W-1:0] alt_word(logic phase);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_W; i++) w[i] = ((i % 2) == 1) ^ phase;
    return w;
  endfunction

  function automatic logic [FRAME_W-1:0] sync_frame(logic two_wire, logic ser14);
    logic [FRAME_W-1:0] f;
    int bits, per, ones;
    bits = ser14 ? FRAME_W : WORD_W;
    per  = two_wire ? bits / 2 : bits;
    ones = (per + 1) / 2;
    for (int i = 0; i < FRAME_W; i++)
      f[i] = (i < bits) && ((i % per) >= (per - ones));
    return f;
  endfunction
endpackage

// File: rtl/atpg_custom_reg.sv
module atpg_custom_reg #(
  parameter int HALF_W = atpg_pkg::HALF_W,
  localparam int W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] hi_i,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] lo_i,
  input  logic              lo_we_i,
  output logic [W-1:0]      word_o
);
  logic [HALF_W-1:0] hi_stage_q, lo_stage_q;
  logic              hi_pend_q, lo_pend_q;
  logic [W-1:0]      active_q;
  logic              commit;
  logic [HALF_W-1:0] hi_new, lo_new;

  assign hi_new = hi_we_i ? hi_i : hi_stage_q;
  assign lo_new = lo_we_i ? lo_i : lo_stage_q;
  assign commit = (hi_we_i | hi_pend_q) & (lo_we_i | lo_pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_stage_q <= '0;
      lo_stage_q <= '0;
      hi_pend_q  <= 1'b0;
      lo_pend_q  <= 1'b0;
      active_q   <= '0;
    end else begin
      hi_stage_q <= hi_new;
      lo_stage_q <= lo_new;
      if (commit) begin
        active_q  <= {hi_new, lo_new};
        hi_pend_q <= 1'b0;
        lo_pend_q <= 1'b0;
      end else begin
        hi_pend_q <= hi_pend_q | hi_we_i;
        lo_pend_q <= lo_pend_q | lo_we_i;
      end
    end
  end

  assign word_o = active_q;

  assert_idle_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_we_i || lo_we_i) |=> $stable(word_o));
  assert_lone_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && !lo_we_i && !lo_pend_q) |=> $stable(word_o));
  assert_lone_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !hi_we_i && !hi_pend_q) |=> $stable(word_o));
  assert_pair_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && lo_we_i) |=> word_o == $past({hi_i, lo_i}));
endmodule

// File: rtl/atpg_pattern_sel.sv
module atpg_pattern_sel
  import atpg_pkg::*;
#(
  parameter bit DESKEW_INV = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [2:0]         mode_i,
  input  logic               two_wire_i,
  input  logic               ser14_i,
  input  logic [WORD_W-1:0]  custom_i,
  output logic [FRAME_W-1:0] pat_o,
  output logic               pass_o
);
  mode_e mode, last_mode_q;
  logic  phase_q, phase_eff;

  assign mode      = mode_e'(mode_i);
  assign phase_eff = (mode == last_mode_q) ? phase_q : 1'b0;
  assign pass_o    = (mode == MODE_PASS) || (mode == MODE_PASS_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_mode_q <= MODE_PASS;
      phase_q     <= 1'b0;
    end else if (tick_i) begin
      last_mode_q <= mode;
      phase_q     <= ~phase_eff;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_ZEROS:  pat_o = '0;
      MODE_ONES:   pat_o = active_mask(ser14_i);
      MODE_TOGGLE: pat_o = align_word(alt_word(phase_eff), ser14_i);
      MODE_CUSTOM: pat_o = align_word(custom_i, ser14_i);
      MODE_SYNC:   pat_o = sync_frame(two_wire_i, ser14_i);
      MODE_DESKEW: pat_o = align_word(alt_word(DESKEW_INV), ser14_i);
      default:     pat_o = '0;
    endcase
  end
endmodule

// File: rtl/atpg_lane_fmt.sv
module atpg_lane_fmt
  import atpg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               pass_i,
  input  logic               ser14_i,
  input  logic [WORD_W-1:0]  sample_i,
  input  logic [FRAME_W-1:0] pat_i,
  output logic [FRAME_W-1:0] frame_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_o <= '0;
    else if (tick_i) frame_o <= pass_i ? align_word(sample_i, ser14_i) : pat_i;
  end
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
  import atpg_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter bit DESKEW_INV = 1'b0,
  localparam int IN_W  = NUM_CH * WORD_W,
  localparam int OUT_W = NUM_CH * FRAME_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              two_wire_i,
  input  logic              ser14_i,
  input  logic [HALF_W-1:0] cust_hi_i,
  input  logic              cust_hi_we_i,
  input  logic [HALF_W-1:0] cust_lo_i,
  input  logic              cust_lo_we_i,
  input  logic              sample_valid_i,
  input  logic [IN_W-1:0]   sample_i,
  output logic [OUT_W-1:0]  frame_o,
  output logic              valid_o
);
  logic [WORD_W-1:0]  custom_word;
  logic [FRAME_W-1:0] pat;
  logic               pass;

  atpg_custom_reg #(.HALF_W(HALF_W)) u_custom (
    .clk_i, .rst_ni,
    .hi_i(cust_hi_i), .hi_we_i(cust_hi_we_i),
    .lo_i(cust_lo_i), .lo_we_i(cust_lo_we_i),
    .word_o(custom_word)
  );

  atpg_pattern_sel #(.DESKEW_INV(DESKEW_INV)) u_sel (
    .clk_i, .rst_ni,
    .tick_i(sample_valid_i), .mode_i, .two_wire_i, .ser14_i,
    .custom_i(custom_word), .pat_o(pat), .pass_o(pass)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    atpg_lane_fmt u_fmt (
      .clk_i, .rst_ni,
      .tick_i(sample_valid_i), .pass_i(pass), .ser14_i,
      .sample_i(sample_i[k*WORD_W +: WORD_W]), .pat_i(pat),
      .frame_o(frame_o[k*FRAME_W +: FRAME_W])
    );
    if (k > 0) begin : g_eq
      assert_lanes_equal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(mode_i) != 3'd0 && $past(mode_i) != 3'd7)
          |-> frame_o[k*FRAME_W +: FRAME_W] == frame_o[FRAME_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= sample_valid_i;
  end

  assert_valid_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> valid_o);
  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> (!valid_o && $stable(frame_o)));
  assert_zeros_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 3'd1) |-> frame_o[FRAME_W-1:0] == '0);
  assert_ones_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 3'd2)
      |-> frame_o[FRAME_W-1:0] == ($past(ser14_i) ? 14'h3FFF : 14'h0FFF));
  assert_deskew_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 3'd6 && !$past(ser14_i) && !DESKEW_INV)
      |-> frame_o[FRAME_W-1:0] == 14'h0AAA);
  assert_passthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(mode_i) == 3'd0 || $past(mode_i) == 3'd7) && !$past(ser14_i))
      |-> frame_o[FRAME_W-1:0] == {2'b00, $past(sample_i[WORD_W-1:0])});
endmodule

// File: tb/adc_test_pattern_gen_bench.sv
`timescale 1ns/1ps
module adc_test_pattern_gen_bench;
  localparam int NCH = 4;
  localparam int FW  = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic        two_wire = 1'b0, ser14 = 1'b0;
  logic [5:0]  hi = '0, lo = '0;
  logic        hi_we = 1'b0, lo_we = 1'b0;
  logic        sv = 1'b0;
  logic [47:0] samp;
  logic [55:0] frame;
  logic        valid;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_test_pattern_gen u_adc_test_pattern_gen (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .two_wire_i(two_wire), .ser14_i(ser14),
    .cust_hi_i(hi), .cust_hi_we_i(hi_we), .cust_lo_i(lo), .cust_lo_we_i(lo_we),
    .sample_valid_i(sv), .sample_i(samp), .frame_o(frame), .valid_o(valid)
  );

  // mode, two_wire, ser14, expected ch0 frame
  localparam logic [18:0] VEC [20] = '{
    {3'd1, 1'b0, 1'b0, 14'h0000}, {3'd1, 1'b0, 1'b1, 14'h0000},
    {3'd2, 1'b0, 1'b0, 14'h0FFF}, {3'd2, 1'b0, 1'b1, 14'h3FFF},
    {3'd3, 1'b0, 1'b0, 14'h0AAA}, {3'd3, 1'b0, 1'b0, 14'h0555},
    {3'd3, 1'b0, 1'b0, 14'h0AAA}, {3'd3, 1'b0, 1'b1, 14'h1554},
    {3'd4, 1'b0, 1'b0, 14'h0CCD}, {3'd4, 1'b0, 1'b1, 14'h3334},
    {3'd5, 1'b0, 1'b0, 14'h0FC0}, {3'd5, 1'b0, 1'b1, 14'h3F80},
    {3'd5, 1'b1, 1'b0, 14'h0E38}, {3'd5, 1'b1, 1'b1, 14'h3C78},
    {3'd6, 1'b0, 1'b0, 14'h0AAA}, {3'd6, 1'b0, 1'b0, 14'h0AAA},
    {3'd6, 1'b0, 1'b1, 14'h2AA8}, {3'd0, 1'b0, 1'b0, 14'h05C3},
    {3'd7, 1'b0, 1'b1, 14'h170C}, {3'd3, 1'b0, 1'b0, 14'h0AAA}
  };

  task automatic chk(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic word(logic [2:0] m, logic tw, logic s14);
    @(negedge clk);
    mode = m; two_wire = tw; ser14 = s14; sv = 1'b1;
    @(negedge clk);
    sv = 1'b0;
    chk("R9 valid", {13'd0, valid}, 14'd1);
  endtask

  task automatic wr(logic dh, logic [5:0] vh, logic dl, logic [5:0] vl);
    @(negedge clk);
    hi = vh; lo = vl; hi_we = dh; lo_we = dl;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) samp[k*12 +: 12] = 12'h5C3 + 12'(k);
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 valid", {13'd0, valid}, 14'd0);
    for (int k = 0; k < NCH; k++) chk("R10 frame", frame[k*FW +: FW], 14'h0);
    word(3'd4, 1'b0, 1'b0);
    chk("R10 custom", frame[FW-1:0], 14'h0);

    wr(1'b1, 6'b110011, 1'b1, 6'b001101);
    for (int i = 0; i < 20; i++) begin
      word(VEC[i][18:16], VEC[i][15], VEC[i][14]);
      chk($sformatf("R1/R2/R4/R6/R7/R8 vec %0d", i), frame[FW-1:0], VEC[i][13:0]);
      for (int k = 1; k < NCH; k++) begin
        if (VEC[i][18:16] == 3'd0 || VEC[i][18:16] == 3'd7)
          chk("R7 lane", frame[k*FW +: FW],
              VEC[i][14] ? {12'h5C3 + 12'(k), 2'b00} : {2'b00, 12'h5C3 + 12'(k)});
        else
          chk("R5 lane", frame[k*FW +: FW], frame[FW-1:0]);
      end
    end

    // R9 hold with no strobe
    repeat (3) @(negedge clk);
    mode = 3'd2;
    @(negedge clk);
    chk("R9 idle valid", {13'd0, valid}, 14'd0);
    chk("R9 hold", frame[FW-1:0], 14'h0AAA);

    // R3 custom ordering
    wr(1'b1, 6'h3F, 1'b0, 6'h00);
    word(3'd4, 1'b0, 1'b0);
    chk("R3 lone hi", frame[FW-1:0], 14'h0CCD);
    wr(1'b0, 6'h00, 1'b1, 6'h00);
    word(3'd4, 1'b0, 1'b0);
    chk("R3 hi then lo", frame[FW-1:0], 14'h0FC0);
    wr(1'b1, 6'h01, 1'b1, 6'h02);
    word(3'd4, 1'b0, 1'b0);
    chk("R3 same cycle", frame[FW-1:0], 14'h0042);
    wr(1'b0, 6'h00, 1'b1, 6'h3F);
    word(3'd4, 1'b0, 1'b0);
    chk("R3 lone lo", frame[FW-1:0], 14'h0042);
    wr(1'b1, 6'h2A, 1'b0, 6'h00);
    word(3'd4, 1'b0, 1'b0);
    chk("R3 lo then hi", frame[FW-1:0], 14'h0ABF);

    // R2 toggle counts words, restarts after a mode change
    word(3'd3, 1'b0, 1'b0);
    chk("R2 first", frame[FW-1:0], 14'h0AAA);
    repeat (4) @(negedge clk);
    word(3'd3, 1'b0, 1'b0);
    chk("R2 gap", frame[FW-1:0], 14'h0555);
    word(3'd1, 1'b0, 1'b0);
    word(3'd3, 1'b0, 1'b0);
    chk("R2 restart", frame[FW-1:0], 14'h0AAA);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule